// File: doc/BRIEF.md
# BCD Calendar Clock Counter

This block keeps wall-clock time and calendar date in packed BCD. It counts one-cycle tick enables from a 32.768 kHz source through a sub-second divider. Each time the divider completes a second, the block advances seconds, then minutes, hours, day of week, date, month and year, with carries between them. The hour field can run in a 24-hour format or a 12-hour format with an AM/PM bit. The date wraps at the correct last day of each month, leap Februaries included, and a century bit in the month byte flips when the year wraps.

Software loads any field through a one-cycle write port. A write to the seconds field restarts the divider, so the 1 Hz phase output lines up with that write. An oscillator-disable input freezes timekeeping. A sticky stop flag records that time may be invalid: it is set at reset and whenever the oscillator is disabled, and software can only clear it.

Top module: `rtc_bcd_calendar`

## Requirements
- R1: After reset the outputs read sec 8'h00, min 8'h00, hour 8'h00 (24-hour), dow 8'h01, date 8'h01, month 8'h01 (century bit 0), year 8'h00, stop flag 1 and 1 Hz phase 0.
- R2: A write with `wr_en_i` high loads the field chosen by `wr_addr_i` (0 seconds, 1 minutes, 2 hours, 3 day of week, 4 date, 5 month, 6 year) and is visible on the next cycle. The data is masked with 7F, 7F, 7F, 07, 3F, 9F and FF respectively.
- R3: A second passes every TICK_HZ accepted ticks. Seconds and minutes count 00 to 59 in BCD, and 59 wraps to 00 with a carry to the next field.
- R4: With hour bit 6 at 0 (24-hour), hours count 00 to 23 in BCD, and 23 wraps to 00 with a carry into the day.
- R5: With hour bit 6 at 1 (12-hour), bits 4:0 hold 1 to 12 in BCD and bit 5 is PM. 11 goes to 12 and flips bit 5, 12 goes to 1, and only 11 PM to 12 AM carries into the day.
- R6: At a day carry the date goes to 01 after the last day of the month: 31, or 30 for months 04, 06, 09 and 11, or for month 02 either 29 when the BCD year is a multiple of four or 28 otherwise. In every other case the date increments.
- R7: After date wrap, month 12 goes to 01 with a carry to the year. Year 99 goes to 00 and toggles month bit 7 (the century bit).
- R8: Day of week increments on each day carry, and 7 wraps to 1.
- R9: A seconds write restarts the divider. The 1 Hz phase is low after the write, rises after TICK_HZ/2 further ticks, and falls as seconds advance after TICK_HZ ticks.
- R10: While `osc_off_i` is 1, ticks are ignored (time and phase hold) and the stop flag is set.
- R11: A write to address 7 clears the stop flag when data bit 7 is 0 and leaves it unchanged when bit 7 is 1. The flag cannot be cleared while `osc_off_i` is 1.
- R12: A tick in the same cycle as any write is discarded. The divider does not count it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle 32.768 kHz tick enable |
| osc_off_i | input | 1 | 1 stops timekeeping |
| wr_en_i | input | 1 | Field write strobe |
| wr_addr_i | input | 3 | Field select (0-6 time/date, 7 status) |
| wr_data_i | input | 8 | Write data |
| sec_o | output | 8 | BCD seconds |
| min_o | output | 8 | BCD minutes |
| hour_o | output | 8 | Hours with mode and AM/PM bits |
| dow_o | output | 8 | Day of week 1-7 |
| date_o | output | 8 | BCD date |
| month_o | output | 8 | Century bit 7, BCD month 4:0 |
| year_o | output | 8 | BCD year |
| pulse_1hz_o | output | 1 | 1 Hz phase output |
| stop_flag_o | output | 1 | Oscillator-stop flag |

## Verification
The bench builds the block with TICK_HZ set to 8, so a second takes only eight ticks and the half-second phase edge comes after four. This puts every rollover within a few dozen cycles of a load: minute and hour carries, both hour formats, short months and leap Februaries, year and century wrap, and day-of-week wrap. The small divider also makes it possible to check the phase edges and the swallowed tick tick by tick.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

    localparam logic [2:0] ADR_SEC   = 3'd0;
    localparam logic [2:0] ADR_MIN   = 3'd1;
    localparam logic [2:0] ADR_HOUR  = 3'd2;
    localparam logic [2:0] ADR_DOW   = 3'd3;
    localparam logic [2:0] ADR_DATE  = 3'd4;
    localparam logic [2:0] ADR_MONTH = 3'd5;
    localparam logic [2:0] ADR_YEAR  = 3'd6;
    localparam logic [2:0] ADR_STAT  = 3'd7;

    typedef struct packed {
        logic [7:0] sec;
        logic [7:0] min;
        logic [7:0] hour;
        logic [7:0] dow;
        logic [7:0] date;
        logic [7:0] month;
        logic [7:0] year;
        logic       stop_flag;
    } rtc_state_t;

    localparam rtc_state_t RTC_RESET = '{
        sec: 8'h00, min: 8'h00, hour: 8'h00, dow: 8'h01,
        date: 8'h01, month: 8'h01, year: 8'h00, stop_flag: 1'b1
    };

    // BCD increment of a two-digit byte; a bad low digit carries so nothing sticks
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] >= 4'd9)
            return {v[7:4] + 4'd1, 4'd0};
        else
            return {v[7:4], v[3:0] + 4'd1};
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int unsigned TICK_HZ = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic restart_i,
    output logic sec_pulse_o,
    output logic phase_o
);
    localparam int unsigned CW = (TICK_HZ > 2) ? $clog2(TICK_HZ) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_HZ - 1);
    localparam logic [CW-1:0] HALF = CW'(TICK_HZ / 2);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (restart_i)
            cnt_d = '0;
        else if (tick_i)
            cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    assign sec_pulse_o = tick_i && !restart_i && (cnt_q == LAST);
    assign phase_o     = (cnt_q >= HALF);

endmodule

// File: rtl/rtc_hour_next.sv
module rtc_hour_next
    import rtc_cal_pkg::*;
(
    input  logic [6:0] hour_i,
    output logic [7:0] hour_o,
    output logic       day_wrap_o
);
    logic [7:0] inc24, inc12;
    logic       pm;

    always_comb begin
        inc24      = bcd_inc({2'b00, hour_i[5:0]});
        inc12      = bcd_inc({3'b000, hour_i[4:0]});
        pm         = hour_i[5];
        hour_o     = 8'h00;
        day_wrap_o = 1'b0;
        if (!hour_i[6]) begin
            if (hour_i[5:0] >= 6'h23) begin
                hour_o     = 8'h00;
                day_wrap_o = 1'b1;
            end else begin
                hour_o = {2'b00, inc24[5:0]};
            end
        end else begin
            if (hour_i[4:0] >= 5'h12) begin
                hour_o = {2'b01, pm, 5'h01};
            end else if (hour_i[4:0] == 5'h11) begin
                hour_o     = {2'b01, ~pm, 5'h12};
                day_wrap_o = pm;
            end else begin
                hour_o = {2'b01, pm, inc12[4:0]};
            end
        end
    end

endmodule

// File: rtl/rtc_month_end.sv
module rtc_month_end (
    input  logic [4:0] month_i,
    input  logic [7:0] year_i,
    output logic [7:0] last_date_o
);
    logic [7:0] year_bin;
    logic       leap;

    always_comb begin
        year_bin = ({4'b0000, year_i[7:4]} * 8'd10) + {4'b0000, year_i[3:0]};
        leap     = (year_bin[1:0] == 2'b00);
        case (month_i)
            5'h02:                      last_date_o = leap ? 8'h29 : 8'h28;
            5'h04, 5'h06, 5'h09, 5'h11: last_date_o = 8'h30;
            default:                    last_date_o = 8'h31;
        endcase
    end

endmodule

// File: rtl/rtc_bcd_calendar.sv
module rtc_bcd_calendar
    import rtc_cal_pkg::*;
#(
    parameter int unsigned TICK_HZ = 32768
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       osc_off_i,
    input  logic       wr_en_i,
    input  logic [2:0] wr_addr_i,
    input  logic [7:0] wr_data_i,
    output logic [7:0] sec_o,
    output logic [7:0] min_o,
    output logic [7:0] hour_o,
    output logic [7:0] dow_o,
    output logic [7:0] date_o,
    output logic [7:0] month_o,
    output logic [7:0] year_o,
    output logic       pulse_1hz_o,
    output logic       stop_flag_o
);
    rtc_state_t st_d, st_q;

    logic       tick_en, restart, sec_pulse;
    logic [7:0] hour_nxt, last_date, month_inc;
    logic       day_wrap;

    assign tick_en = tick_i && !osc_off_i && !wr_en_i;
    assign restart = wr_en_i && (wr_addr_i == ADR_SEC);

    rtc_prescaler #(.TICK_HZ(TICK_HZ)) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_en),
        .restart_i  (restart),
        .sec_pulse_o(sec_pulse),
        .phase_o    (pulse_1hz_o)
    );

    rtc_hour_next u_hour (
        .hour_i    (st_q.hour[6:0]),
        .hour_o    (hour_nxt),
        .day_wrap_o(day_wrap)
    );

    rtc_month_end u_mend (
        .month_i    (st_q.month[4:0]),
        .year_i     (st_q.year),
        .last_date_o(last_date)
    );

    assign month_inc = bcd_inc({3'b000, st_q.month[4:0]});

    always_comb begin
        st_d = st_q;
        // carry chain, one level per field
        if (sec_pulse) begin
            if (st_q.sec >= 8'h59) begin
                st_d.sec = 8'h00;
                if (st_q.min >= 8'h59) begin
                    st_d.min  = 8'h00;
                    st_d.hour = hour_nxt;
                    if (day_wrap) begin
                        st_d.dow = (st_q.dow >= 8'h07) ? 8'h01 : st_q.dow + 8'h01;
                        if (st_q.date >= last_date) begin
                            st_d.date = 8'h01;
                            if (st_q.month[4:0] >= 5'h12) begin
                                if (st_q.year >= 8'h99) begin
                                    st_d.year  = 8'h00;
                                    st_d.month = {~st_q.month[7], 7'h01};
                                end else begin
                                    st_d.year  = bcd_inc(st_q.year);
                                    st_d.month = {st_q.month[7], 7'h01};
                                end
                            end else begin
                                st_d.month = {st_q.month[7], 2'b00, month_inc[4:0]};
                            end
                        end else begin
                            st_d.date = bcd_inc(st_q.date);
                        end
                    end
                end else begin
                    st_d.min = bcd_inc(st_q.min);
                end
            end else begin
                st_d.sec = bcd_inc(st_q.sec);
            end
        end

        // software load wins over the (already suppressed) advance
        if (wr_en_i) begin
            case (wr_addr_i)
                ADR_SEC:   st_d.sec   = wr_data_i & 8'h7F;
                ADR_MIN:   st_d.min   = wr_data_i & 8'h7F;
                ADR_HOUR:  st_d.hour  = wr_data_i & 8'h7F;
                ADR_DOW:   st_d.dow   = wr_data_i & 8'h07;
                ADR_DATE:  st_d.date  = wr_data_i & 8'h3F;
                ADR_MONTH: st_d.month = wr_data_i & 8'h9F;
                ADR_YEAR:  st_d.year  = wr_data_i;
                ADR_STAT:  if (!wr_data_i[7]) st_d.stop_flag = 1'b0;
                default:   ;
            endcase
        end

        if (osc_off_i)
            st_d.stop_flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= RTC_RESET;
        else
            st_q <= st_d;
    end

    assign sec_o       = st_q.sec;
    assign min_o       = st_q.min;
    assign hour_o      = st_q.hour;
    assign dow_o       = st_q.dow;
    assign date_o      = st_q.date;
    assign month_o     = st_q.month;
    assign year_o      = st_q.year;
    assign stop_flag_o = st_q.stop_flag;

endmodule

// File: rtl/rtc_cal_checker.sv
module rtc_cal_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       osc_off_i,
    input logic       wr_en_i,
    input logic [2:0] wr_addr_i,
    input logic [7:0] wr_data_i,
    input logic [7:0] sec_o,
    input logic [7:0] month_o,
    input logic [7:0] year_o,
    input logic       pulse_1hz_o,
    input logic       stop_flag_o
);
    AST_SEC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i == 3'd0) |=> (sec_o == ($past(wr_data_i) & 8'h7F))); // R2

    AST_PHASE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i == 3'd0) |=> !pulse_1hz_o); // R9

    AST_CENTURY_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en_i && year_o == 8'h99) |=> ((year_o == 8'h99) || (month_o[7] != $past(month_o[7])))); // R7

    AST_FROZEN_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (osc_off_i && !wr_en_i) |=> ($stable(sec_o) && $stable(pulse_1hz_o))); // R10

    AST_FLAG_WHILE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        osc_off_i |=> stop_flag_o); // R10

    AST_FLAG_NOT_SET_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!stop_flag_o && !osc_off_i) |=> !stop_flag_o); // R11

    AST_WRITE_EATS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i != 3'd0) |=> $stable(sec_o)); // R12
endmodule

bind rtc_bcd_calendar rtc_cal_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .osc_off_i  (osc_off_i),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .sec_o      (sec_o),
    .month_o    (month_o),
    .year_o     (year_o),
    .pulse_1hz_o(pulse_1hz_o),
    .stop_flag_o(stop_flag_o)
);

// File: tb/sim_rtc_bcd_calendar.sv
`timescale 1ns/1ps
module sim_rtc_bcd_calendar;
    localparam int unsigned TICK_HZ = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0, osc_off = 1'b0, wr_en = 1'b0;
    logic [2:0] wr_addr = 3'd0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] sec, min, hour, dow, date, month, year;
    logic       phase, flag;

    int nchk = 0, nfail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    rtc_bcd_calendar #(.TICK_HZ(TICK_HZ)) u0 (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .osc_off_i(osc_off),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .sec_o(sec), .min_o(min), .hour_o(hour), .dow_o(dow), .date_o(date),
        .month_o(month), .year_o(year), .pulse_1hz_o(phase), .stop_flag_o(flag)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic set_time(input logic [7:0] h, mi, s, dw, dt, mo, yr);
        wr(3'd6, yr); wr(3'd5, mo); wr(3'd4, dt); wr(3'd3, dw);
        wr(3'd2, h);  wr(3'd1, mi); wr(3'd0, s);
    endtask

    task automatic t_reset;
        chk("R1 sec", sec, 8'h00);   chk("R1 min", min, 8'h00);
        chk("R1 hour", hour, 8'h00); chk("R1 dow", dow, 8'h01);
        chk("R1 date", date, 8'h01); chk("R1 month", month, 8'h01);
        chk("R1 year", year, 8'h00); chk("R1 flag", {7'd0, flag}, 8'h01);
        chk("R1 phase", {7'd0, phase}, 8'h00);
    endtask

    task automatic t_flag_clear;
        wr(3'd7, 8'h80); chk("R11 write one keeps flag", {7'd0, flag}, 8'h01);
        wr(3'd7, 8'h00); chk("R11 write zero clears", {7'd0, flag}, 8'h00);
    endtask

    task automatic t_masks;
        wr(3'd3, 8'hFF); chk("R2 dow mask", dow, 8'h07);
        wr(3'd4, 8'hFF); chk("R2 date mask", date, 8'h3F);
        wr(3'd5, 8'hFF); chk("R2 month mask", month, 8'h9F);
        wr(3'd1, 8'hA5); chk("R2 min mask", min, 8'h25);
    endtask

    task automatic t_sec_min;
        set_time(8'h05, 8'h00, 8'h58, 8'h02, 8'h10, 8'h05, 8'h20);
        ticks(TICK_HZ - 1); chk("R3 no advance early", sec, 8'h58);
        ticks(1);           chk("R3 sec step", sec, 8'h59);
        ticks(TICK_HZ);     chk("R3 sec wrap", sec, 8'h00);
        chk("R3 min carry", min, 8'h01);
        set_time(8'h05, 8'h59, 8'h59, 8'h02, 8'h10, 8'h05, 8'h20);
        ticks(TICK_HZ);     chk("R3 min wrap", min, 8'h00);
        chk("R4 hour carry", hour, 8'h06);
    endtask

    task automatic t_24h;
        set_time(8'h23, 8'h59, 8'h59, 8'h03, 8'h15, 8'h03, 8'h21);
        ticks(TICK_HZ);
        chk("R4 23 to 00", hour, 8'h00); chk("R4 date carry", date, 8'h16);
        chk("R8 dow step", dow, 8'h04);
        set_time(8'h19, 8'h59, 8'h59, 8'h03, 8'h15, 8'h03, 8'h21);
        ticks(TICK_HZ); chk("R4 19 to 20", hour, 8'h20);
    endtask

    task automatic t_12h;
        set_time(8'h51, 8'h59, 8'h59, 8'h02, 8'h10, 8'h06, 8'h22);
        ticks(TICK_HZ); chk("R5 11AM to 12PM", hour, 8'h72);
        chk("R5 no day carry at noon", date, 8'h10);
        set_time(8'h72, 8'h59, 8'h59, 8'h02, 8'h10, 8'h06, 8'h22);
        ticks(TICK_HZ); chk("R5 12PM to 1PM", hour, 8'h61);
        set_time(8'h71, 8'h59, 8'h59, 8'h02, 8'h10, 8'h06, 8'h22);
        ticks(TICK_HZ); chk("R5 11PM to 12AM", hour, 8'h52);
        chk("R5 midnight date", date, 8'h11);
    endtask

    task automatic t_months;
        set_time(8'h23, 8'h59, 8'h59, 8'h01, 8'h28, 8'h02, 8'h24);
        ticks(TICK_HZ); chk("R6 leap feb 29", date, 8'h29); chk("R6 leap month", month, 8'h02);
        set_time(8'h23, 8'h59, 8'h59, 8'h01, 8'h29, 8'h02, 8'h24);
        ticks(TICK_HZ); chk("R6 feb 29 wrap", date, 8'h01); chk("R6 to march", month, 8'h03);
        set_time(8'h23, 8'h59, 8'h59, 8'h01, 8'h28, 8'h02, 8'h23);
        ticks(TICK_HZ); chk("R6 common feb wrap", date, 8'h01); chk("R6 common month", month, 8'h03);
        set_time(8'h23, 8'h59, 8'h59, 8'h01, 8'h30, 8'h04, 8'h23);
        ticks(TICK_HZ); chk("R6 april wrap", date, 8'h01); chk("R6 to may", month, 8'h05);
        set_time(8'h23, 8'h59, 8'h59, 8'h01, 8'h30, 8'h01, 8'h23);
        ticks(TICK_HZ); chk("R6 jan 31 reached", date, 8'h31);
    endtask

    task automatic t_year;
        set_time(8'h23, 8'h59, 8'h59, 8'h07, 8'h31, 8'h12, 8'h41);
        ticks(TICK_HZ);
        chk("R7 dec wrap month", month, 8'h01); chk("R7 year step", year, 8'h42);
        chk("R8 dow 7 to 1", dow, 8'h01);
        set_time(8'h23, 8'h59, 8'h59, 8'h05, 8'h31, 8'h12, 8'h99);
        ticks(TICK_HZ);
        chk("R7 year 99 wrap", year, 8'h00); chk("R7 century set", month, 8'h81);
    endtask

    task automatic t_phase;
        wr(3'd0, 8'h30);
        chk("R9 phase low after write", {7'd0, phase}, 8'h00);
        ticks(TICK_HZ / 2 - 1); chk("R9 phase still low", {7'd0, phase}, 8'h00);
        ticks(1);               chk("R9 phase rises at half", {7'd0, phase}, 8'h01);
        ticks(TICK_HZ / 2 - 1); chk("R9 sec held", sec, 8'h30);
        ticks(1);
        chk("R9 sec step on fall", sec, 8'h31); chk("R9 phase falls", {7'd0, phase}, 8'h00);
    endtask

    task automatic t_osc_off;
        logic [7:0] s0;
        logic       p0;
        ticks(3);
        s0 = sec; p0 = phase;
        @(negedge clk); osc_off = 1'b1;
        ticks(3 * TICK_HZ);
        chk("R10 sec frozen", sec, s0);
        chk("R10 phase frozen", {7'd0, phase}, {7'd0, p0});
        chk("R10 flag set", {7'd0, flag}, 8'h01);
        wr(3'd7, 8'h00);
        chk("R11 clear blocked while off", {7'd0, flag}, 8'h01);
        @(negedge clk); osc_off = 1'b0;
        wr(3'd7, 8'h00);
        chk("R11 clear after restart", {7'd0, flag}, 8'h00);
    endtask

    task automatic t_write_tick;
        wr(3'd0, 8'h10);
        ticks(TICK_HZ - 1);
        @(negedge clk);
        tick = 1'b1; wr_en = 1'b1; wr_addr = 3'd1; wr_data = 8'h22;
        @(negedge clk);
        tick = 1'b0; wr_en = 1'b0;
        chk("R12 tick discarded", sec, 8'h10);
        chk("R12 write landed", min, 8'h22);
        ticks(1);
        chk("R12 next tick counts", sec, 8'h11);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_flag_clear;
        t_masks;
        t_sec_min;
        t_24h;
        t_12h;
        t_months;
        t_year;
        t_phase;
        t_osc_off;
        t_write_tick;
        done = 1'b1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule